// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction per clock. In each cycle it presents the program counter on an instruction port and decodes the returned word. It reads up to two operands from a 32-entry register file and computes a result or an address. It then writes the register file and picks the next program counter, all before the next rising edge. Instructions come in three fixed 32-bit layouts. The register layout picks its operation from a 6-bit function field. The immediate layout carries a 16-bit constant or displacement. The jump layout carries a 26-bit word target.

Data traffic uses a separate port with a byte address, write data and four byte strobes, one per lane. The read data must arrive in the same cycle, from a combinational memory. Byte loads pick one lane of the returned word. Byte stores copy the byte onto every lane and enable only the addressed lane. Lane 0 is bits [7:0] and is selected by address bits [1:0] = 0.

Top module: `sc32_core`

## Requirements
- R1: While `rst_n` is low at a rising edge the program counter becomes 0 and no byte strobe is driven. The first fetch after reset is from address 0, and the one after that is from address 4.
- R2: With opcode 0, funct 32 writes rs+rt to rd, funct 34 writes rs-rt to rd, and funct 42 writes 1 to rd when rs is less than rt as signed numbers, otherwise 0.
- R3: Opcode 8 writes rs plus the sign-extended immediate to rt. Opcode 10 writes 1 to rt when rs is signed-less-than the sign-extended immediate, otherwise 0. Opcode 13 writes rs ORed with the zero-extended immediate to rt.
- R4: Opcode 15 writes the immediate into bits [31:16] of rt and zeros into bits [15:0].
- R5: Register 0 reads as zero, and writes aimed at it are discarded.
- R6: Opcode 35 loads the word at rs plus the sign-extended displacement into rt. Opcode 43 stores rt at that address with all four strobes set.
- R7: Opcode 32 loads the addressed byte, selected little-endian by address bits [1:0], and sign-extends it into rt. Opcode 40 drives only the strobe of the addressed lane and places rt[7:0] on that lane. Only one lane of the word changes.
- R8: Opcode 4 (taken when rs equals rt) and opcode 5 (taken when they differ) go to PC+4+(offset×4). The offset may be negative. When not taken the core goes to PC+4.
- R9: Opcodes 2 and 3 go to {PC+4 bits [31:28], target, 00}. Opcode 3 also writes PC+4 into register 31.
- R10: Opcode 0 with funct 8 loads the program counter with the value of rs.
- R11: An opcode, or an opcode-0 funct, that is not listed above changes no register and no memory, and the core continues at PC+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction to fetch (current PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data, lane-replicated for byte stores |
| dmem_wstrb | output | 4 | Per-lane write strobes, bit n enables bits [8n+7:8n] |
| dmem_rdata | input | 32 | Word containing `dmem_addr`, same cycle |

## Verification
The assertions take for granted that the program counter stays word-aligned. This holds only while every jump-register source holds a multiple of 4 and word accesses use aligned addresses. The assertions also assume that both memories answer combinationally in the cycle of the request. The bench programs load addresses and jump-register sources only with multiples of 4. Its memory models return data from the presented address without delay. The arithmetic sweep builds every operand with an upper-then-OR constant pair and keeps all data addresses inside the modelled 1 KiB.

// File: rtl/sc32_pkg.sv
// Shared encodings and control types of the single-cycle core.
// Assumes the fixed 32-bit three-layout instruction encoding.
package sc32_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);
    localparam int NBYTE = XLEN / 8;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_J     = 6'd2;
    localparam logic [5:0] OP_JAL   = 6'd3;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_BNE   = 6'd5;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_SLTI  = 6'd10;
    localparam logic [5:0] OP_ORI   = 6'd13;
    localparam logic [5:0] OP_LUI   = 6'd15;
    localparam logic [5:0] OP_LB    = 6'd32;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SB    = 6'd40;
    localparam logic [5:0] OP_SW    = 6'd43;

    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    localparam logic [RIDX-1:0] LINK_REG = RIDX'(NREG - 1);

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_OR, ALU_HIGH} alu_op_e;
    typedef enum logic [1:0] {PC_SEQ, PC_BR, PC_JMP, PC_REG} pc_sel_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;

    typedef struct packed {
        logic            reg_we;
        logic [RIDX-1:0] dst;
        alu_op_e         alu_op;
        logic            use_imm;
        logic            imm_zext;
        logic            mem_wr;
        logic            mem_byte;
        pc_sel_e         pc_sel;
        logic            br_ne;
        wb_sel_e         wb_sel;
    } ctrl_t;
endpackage

// File: rtl/sc32_decode.sv
// Instruction decoder: turns one instruction word into control fields.
// Assumes the opcode in [31:26]; register-layout words dispatch on [5:0].
// Unlisted opcodes and functions decode to a no-operation.
module sc32_decode
    import sc32_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic [5:0]      op;
    logic [5:0]      fn;
    logic [RIDX-1:0] f_rt;
    logic [RIDX-1:0] f_rd;

    assign op   = instr[31:26];
    assign fn   = instr[5:0];
    assign f_rt = instr[20:16];
    assign f_rd = instr[15:11];

    // Decode the opcode (and function field) into control settings.
    always_comb begin
        ctrl.reg_we   = 1'b0;
        ctrl.dst      = f_rt;
        ctrl.alu_op   = ALU_ADD;
        ctrl.use_imm  = 1'b0;
        ctrl.imm_zext = 1'b0;
        ctrl.mem_wr   = 1'b0;
        ctrl.mem_byte = 1'b0;
        ctrl.pc_sel   = PC_SEQ;
        ctrl.br_ne    = 1'b0;
        ctrl.wb_sel   = WB_ALU;
        case (op)
            OP_RTYPE: begin
                ctrl.dst = f_rd;
                case (fn)
                    FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
                    FN_JR:  ctrl.pc_sel = PC_REG;
                    default: ;
                endcase
            end
            OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
            OP_SLTI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT;
            end
            OP_ORI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1;
                ctrl.imm_zext = 1'b1; ctrl.alu_op = ALU_OR;
            end
            OP_LUI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_HIGH;
            end
            OP_LW, OP_LB: begin
                ctrl.reg_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.wb_sel   = WB_MEM;
                ctrl.mem_byte = (op == OP_LB);
            end
            OP_SW, OP_SB: begin
                ctrl.use_imm  = 1'b1;
                ctrl.mem_wr   = 1'b1;
                ctrl.mem_byte = (op == OP_SB);
            end
            OP_BEQ: ctrl.pc_sel = PC_BR;
            OP_BNE: begin ctrl.pc_sel = PC_BR; ctrl.br_ne = 1'b1; end
            OP_J:   ctrl.pc_sel = PC_JMP;
            OP_JAL: begin
                ctrl.pc_sel = PC_JMP;
                ctrl.reg_we = 1'b1;
                ctrl.dst    = LINK_REG;
                ctrl.wb_sel = WB_LINK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc32_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is hard-wired to zero; a write to it is dropped.
module sc32_regfile #(
    parameter  int N  = 32,
    parameter  int W  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [N];

    // Clear on reset, otherwise write the selected nonzero entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc32_alu.sv
// Arithmetic unit: add, subtract, signed compare, OR, upper-half place.
// Assumes W is even; the upper-half form moves b's low half to the top.
module sc32_alu
    import sc32_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    // Select the result of the requested operation.
    always_comb begin
        case (op)
            ALU_SUB:  y = a - b;
            ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_OR:   y = a | b;
            ALU_HIGH: y = {b[W/2-1:0], {(W/2){1'b0}}};
            default:  y = a + b;
        endcase
    end
endmodule

// File: rtl/sc32_lsu_align.sv
// Byte-lane steering for the data port: store strobes and data, load extract.
// Little-endian lanes; word accesses are assumed aligned by software.
module sc32_lsu_align #(
    parameter  int W  = 32,
    localparam int NB = W / 8,
    localparam int LW = $clog2(NB)
) (
    input  logic [LW-1:0] addr_lo,
    input  logic          byte_op,
    input  logic          wr_en,
    input  logic [W-1:0]  st_src,
    input  logic [W-1:0]  ld_raw,
    output logic [W-1:0]  st_data,
    output logic [NB-1:0] st_strb,
    output logic [W-1:0]  ld_val
);
    logic [7:0] lanes [NB];
    logic [7:0] lane_sel;

    // Split the returned word into lanes.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = ld_raw[8*g +: 8];
    end

    assign lane_sel = lanes[addr_lo];

    // Build store data and strobes for byte or word access.
    always_comb begin
        if (byte_op) begin
            st_data = {NB{st_src[7:0]}};
            st_strb = wr_en ? (NB'(1) << addr_lo) : '0;
        end else begin
            st_data = st_src;
            st_strb = wr_en ? '1 : '0;
        end
    end

    // Return the word, or the sign-extended addressed byte.
    always_comb begin
        ld_val = byte_op ? {{(W-8){lane_sel[7]}}, lane_sel} : ld_raw;
    end
endmodule

// File: rtl/sc32_core.sv
// Single-cycle core: fetch, decode, read, execute, write back each clock.
// Assumes combinational instruction and data memories and an aligned PC.
module sc32_core
    import sc32_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [XLEN-1:0]  imem_addr,
    input  logic [XLEN-1:0]  imem_data,
    output logic [XLEN-1:0]  dmem_addr,
    output logic [XLEN-1:0]  dmem_wdata,
    output logic [NBYTE-1:0] dmem_wstrb,
    input  logic [XLEN-1:0]  dmem_rdata
);
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;
    logic [XLEN-1:0] next_pc;
    logic [15:0]     imm16;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] imm_zx;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] ld_val;
    logic [XLEN-1:0] wb_data;
    logic            br_taken;
    ctrl_t           ctrl;

    assign imem_addr = pc;
    assign imm16     = imem_data[15:0];
    assign imm_sx    = {{(XLEN-16){imm16[15]}}, imm16};
    assign imm_zx    = {{(XLEN-16){1'b0}}, imm16};

    sc32_decode i_decode (
        .instr (imem_data),
        .ctrl  (ctrl)
    );

    sc32_regfile #(.N(NREG), .W(XLEN)) i_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (imem_data[25:21]),
        .ra2   (imem_data[20:16]),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (ctrl.reg_we),
        .wa    (ctrl.dst),
        .wd    (wb_data)
    );

    assign alu_b = ctrl.use_imm ? (ctrl.imm_zext ? imm_zx : imm_sx) : rt_val;

    sc32_alu #(.W(XLEN)) i_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y)
    );

    assign dmem_addr = alu_y;

    sc32_lsu_align #(.W(XLEN)) i_lsu (
        .addr_lo (alu_y[$clog2(NBYTE)-1:0]),
        .byte_op (ctrl.mem_byte),
        .wr_en   (ctrl.mem_wr & rst_n),
        .st_src  (rt_val),
        .ld_raw  (dmem_rdata),
        .st_data (dmem_wdata),
        .st_strb (dmem_wstrb),
        .ld_val  (ld_val)
    );

    assign pc_plus4 = pc + XLEN'(4);
    assign br_tgt   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[XLEN-1:28], imem_data[25:0], 2'b00};
    assign br_taken = (rs_val == rt_val) ^ ctrl.br_ne;

    // Choose the value written back to the register file.
    always_comb begin
        case (ctrl.wb_sel)
            WB_MEM:  wb_data = ld_val;
            WB_LINK: wb_data = pc_plus4;
            default: wb_data = alu_y;
        endcase
    end

    // Choose the next program counter.
    always_comb begin
        case (ctrl.pc_sel)
            PC_BR:   next_pc = br_taken ? br_tgt : pc_plus4;
            PC_JMP:  next_pc = jmp_tgt;
            PC_REG:  next_pc = rs_val;
            default: next_pc = pc_plus4;
        endcase
    end

    // Program counter register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= next_pc;
    end

    AST_RESET_PC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0)); // R1

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_data[25:21] == '0) |-> (rs_val == '0)); // R5

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_sel == PC_SEQ) |=> (pc == $past(pc) + XLEN'(4))); // R11

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_sel == PC_BR && br_taken) |=>
        (pc == $past(pc) + XLEN'(4) + {$past(imm_sx[XLEN-3:0]), 2'b00})); // R8

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.wb_sel == WB_LINK) |-> (ctrl.dst == LINK_REG && wb_data == pc + XLEN'(4))); // R9

    AST_STROBE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_wstrb == '0 || $countones(dmem_wstrb) == 1 || dmem_wstrb == '1)); // R7

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (pc[1:0] == 2'b00)); // R10
endmodule

// File: tb/test_sc32_core.sv
// Bench: runs hand-assembled programs and checks memory results.
module test_sc32_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic [3:0]  dmem_wstrb;
    logic [31:0] imem [256];
    logic [31:0] dmem [256];
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sc32_core i_sc32_core (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_wstrb(dmem_wstrb), .dmem_rdata(dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) begin
        for (int k = 0; k < 4; k++)
            if (dmem_wstrb[k]) dmem[dmem_addr[9:2]][8*k +: 8] <= dmem_wdata[8*k +: 8];
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(int op, int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    function automatic logic [31:0] val(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h0000_8000;
            6: return 32'h1234_5678;
            default: return 32'hFFFF_7FFE;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 256; k++) begin
            imem[k] = 32'h0;
            dmem[k] = 32'h0;
        end
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clear_mem();
    endtask

    task automatic leave_and_run(int n);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] a, b, bs;
        clear_mem();
        imem[0] = enc_i(15, 0, 1, 16'h0001);
        imem[1] = enc_j(2, 1);
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 pc in reset", imem_addr, 32'h0);
        chk("R1 strobes in reset", {28'h0, dmem_wstrb}, 32'h0);
        rst_n = 1'b1;
        chk("R1 first fetch", imem_addr, 32'h0);
        @(negedge clk);
        chk("R1 second fetch", imem_addr, 32'h4);

        // Arithmetic sweep over all operand pairs: R2 R3 R4 R6
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = val(i);
                b = val(j);
                bs = {{16{b[15]}}, b[15:0]};
                enter_reset();
                imem[0]  = enc_i(15, 0, 1, a[31:16]);
                imem[1]  = enc_i(13, 1, 1, a[15:0]);
                imem[2]  = enc_i(15, 0, 2, b[31:16]);
                imem[3]  = enc_i(13, 2, 2, b[15:0]);
                imem[4]  = enc_r(1, 2, 3, 32);
                imem[5]  = enc_r(1, 2, 4, 34);
                imem[6]  = enc_r(1, 2, 5, 42);
                imem[7]  = enc_i(8, 1, 6, b[15:0]);
                imem[8]  = enc_i(10, 1, 7, b[15:0]);
                imem[9]  = enc_i(13, 1, 8, b[15:0]);
                imem[10] = enc_i(15, 0, 9, b[31:16]);
                for (int s = 0; s < 7; s++)
                    imem[11+s] = enc_i(43, 0, 3+s, 16'(4*s));
                imem[18] = enc_j(2, 18);
                leave_and_run(25);
                chk("R2 add", dmem[0], a + b);
                chk("R2 sub", dmem[1], a - b);
                chk("R2 slt", dmem[2], {31'h0, $signed(a) < $signed(b)});
                chk("R3 addi", dmem[3], a + bs);
                chk("R3 slti", dmem[4], {31'h0, $signed(a) < $signed(bs)});
                chk("R3 ori", dmem[5], a | {16'h0, b[15:0]});
                chk("R4 lui", dmem[6], {b[31:16], 16'h0});
            end
        end
        chk("R6 sweep word store lane", dmem[7], 32'h0);

        // R5: register 0
        enter_reset();
        dmem[0] = 32'hDEAD_BEEF;
        dmem[1] = 32'hDEAD_BEEF;
        imem[0] = enc_i(8, 0, 0, 16'h0005);
        imem[1] = enc_i(15, 0, 0, 16'hFFFF);
        imem[2] = enc_r(0, 0, 9, 32);
        imem[3] = enc_i(43, 0, 0, 16'h0000);
        imem[4] = enc_i(43, 0, 9, 16'h0004);
        imem[5] = enc_j(2, 5);
        leave_and_run(12);
        chk("R5 r0 stored", dmem[0], 32'h0);
        chk("R5 r0+r0", dmem[1], 32'h0);

        // R6 R7: word and byte memory access
        enter_reset();
        dmem[15] = 32'hCAFE_F00D;
        dmem[20] = 32'h807F_11F0;
        dmem[22] = 32'h1122_3344;
        imem[0]  = enc_i(8, 0, 1, 16'd64);
        imem[1]  = enc_i(35, 1, 2, 16'hFFFC);
        imem[2]  = enc_i(43, 1, 2, 16'd8);
        imem[3]  = enc_i(32, 1, 3, 16'd16);
        imem[4]  = enc_i(32, 1, 4, 16'd17);
        imem[5]  = enc_i(32, 1, 5, 16'd18);
        imem[6]  = enc_i(32, 1, 6, 16'd19);
        imem[7]  = enc_i(43, 0, 3, 16'd0);
        imem[8]  = enc_i(43, 0, 4, 16'd4);
        imem[9]  = enc_i(43, 0, 5, 16'd8);
        imem[10] = enc_i(43, 0, 6, 16'd12);
        imem[11] = enc_i(15, 0, 7, 16'h1234);
        imem[12] = enc_i(13, 7, 7, 16'h56A5);
        imem[13] = enc_i(40, 1, 7, 16'd26);
        imem[14] = enc_i(40, 1, 7, 16'hFFC0);
        imem[15] = enc_j(2, 15);
        leave_and_run(22);
        chk("R6 lw/sw negative disp", dmem[18], 32'hCAFE_F00D);
        chk("R6 source untouched", dmem[15], 32'hCAFE_F00D);
        chk("R7 sb lane0 over lb lane0", dmem[0], 32'hFFFF_FFA5);
        chk("R7 lb lane1", dmem[1], 32'h0000_0011);
        chk("R7 lb lane2", dmem[2], 32'h0000_007F);
        chk("R7 lb lane3 negative", dmem[3], 32'hFFFF_FF80);
        chk("R7 sb lane2 only", dmem[22], 32'h11A5_3344);

        // R8 R9 R10 R11: control flow and unknown encodings
        enter_reset();
        dmem[3] = 32'h5A5A_5A5A;
        imem[0]  = enc_i(8, 0, 1, 16'd7);
        imem[1]  = enc_i(8, 0, 2, 16'd7);
        imem[2]  = enc_i(8, 0, 3, 16'd9);
        imem[3]  = enc_i(4, 1, 2, 16'd1);
        imem[4]  = enc_i(8, 10, 10, 16'd1);
        imem[5]  = enc_i(5, 1, 3, 16'd1);
        imem[6]  = enc_i(8, 10, 10, 16'd2);
        imem[7]  = enc_i(4, 1, 3, 16'd1);
        imem[8]  = enc_i(8, 10, 10, 16'd4);
        imem[9]  = enc_i(5, 1, 2, 16'd1);
        imem[10] = enc_i(8, 10, 10, 16'd8);
        imem[11] = enc_i(8, 0, 11, 16'd3);
        imem[12] = enc_i(8, 11, 11, 16'hFFFF);
        imem[13] = enc_i(8, 10, 10, 16'd16);
        imem[14] = enc_i(5, 11, 0, 16'hFFFD);
        imem[15] = enc_j(2, 18);
        imem[16] = enc_i(8, 10, 10, 16'd256);
        imem[17] = enc_i(8, 10, 10, 16'd512);
        imem[18] = enc_j(3, 21);
        imem[19] = enc_i(8, 10, 10, 16'd1024);
        imem[20] = enc_j(2, 24);
        imem[21] = enc_i(43, 0, 31, 16'd0);
        imem[22] = enc_i(8, 10, 10, 16'd128);
        imem[23] = enc_r(31, 0, 0, 8);
        imem[24] = enc_i(43, 0, 10, 16'd4);
        imem[25] = {6'h3F, 5'd0, 5'd10, 16'h000C};
        imem[26] = {6'd0, 5'd1, 5'd2, 5'd10, 5'd0, 6'h3F};
        imem[27] = enc_i(43, 0, 10, 16'd8);
        imem[28] = enc_j(2, 28);
        leave_and_run(60);
        chk("R9 jal link value", dmem[0], 32'd76);
        chk("R8 R10 branch/jump path sum", dmem[1], 32'd1212);
        chk("R11 unknown ops keep register", dmem[2], 32'd1212);
        chk("R11 unknown op no store", dmem[3], 32'h5A5A_5A5A);
        chk("R9 self-loop fetch", imem_addr, 32'd112);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule